// File: doc/BRIEF.md
# Four-Phase Accumulator Processor Core

This block is a small multicycle processor built around one accumulator. It steps every instruction through four phases in a fixed order: fetch, decode, operand, execute. A hardwired sequencer drives the register load enables and the datapath selects. The core reaches an external single-port memory through an address register and a data register, and it raises a read strobe or a write strobe to mark each access.

Arithmetic operands go from memory into the data register and then into a staging register that feeds the adder. A second data register holds a value that only four instructions can reach: two copy it to or from the accumulator, and two use it as a memory address for loads and stores. The memory model is combinational on reads. The core raises the read strobe with a valid address during a cycle and captures the data at the end of that cycle. It writes only during execute.

Top module: `acc_cpu`

## Requirements
- R1: Phases run in the order fetch, decode, operand, execute, and execute is followed by fetch. The operand phase lasts two cycles for ADD and SUB and one cycle for every other opcode. A store placed after an ADD therefore raises its write strobe 8 cycles after the ADD's fetch cycle.
- R2: A synchronous active-high reset clears PC, the accumulator, the secondary register and the staging register. The first cycle after reset is a fetch from address 0, with the read strobe high and the write strobe low.
- R3: During fetch the core reads the word at PC and then increments PC. The opcode sits in word bits [15:12] and the direct address in bits [11:0]. The encodings are 0 ADD, 1 SUB, 2 LOD, 3 STD, 4 JMP, 5 CAL, 6 A2S, 7 S2A, 8 LDS, 9 STS.
- R4: ADD and SUB read the word at the address into the staging register, then set A to A plus it or A minus it, modulo 2^16.
- R5: LOD sets A to the word at the address. STD writes A to the address and changes no data register.
- R6: JMP sets PC to the address field and leaves A and the secondary register unchanged.
- R7: CAL writes its own address plus one to memory at the target, then continues execution at the target plus one.
- R8: A2S copies A into the secondary register. S2A copies the secondary register into A.
- R9: LDS loads A from the address held in the low 12 bits of the secondary register. STS writes A to that address. Neither changes the secondary register.
- R10: Opcodes 10 to 15 do nothing except advance PC. They write no memory and leave A and the secondary register as they were.
- R11: The write strobe is raised only in execute and never together with the read strobe. The write address and data come from the address and data registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Memory address, from the address register |
| mem_re | output | 1 | Read strobe; data is captured at the end of the cycle |
| mem_we | output | 1 | Write strobe, committed on the clock edge |
| mem_wdata | output | 16 | Write data, from the data register |
| mem_rdata | input | 16 | Read data returned for mem_addr |

## Verification
The bench builds the core with its default 16-bit word, which gives a 4-bit opcode and a 12-bit direct address. Its memory model decodes the low 8 address bits, so each test program, its operands and its scratch cells all fit in 256 words. At this width, small directed programs can push an ADD past 0xFFFF and a SUB below zero, so the carry and borrow wraparound gets checked. Every unused opcode is also in reach. Result values and strobe cycles are observed at the memory port.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int WORD_W = 16;
    localparam int OPC_W  = 4;

    typedef enum logic [1:0] {
        PH_FETCH   = 2'd0,
        PH_DECODE  = 2'd1,
        PH_OPERAND = 2'd2,
        PH_EXEC    = 2'd3
    } phase_t;

    typedef enum logic [OPC_W-1:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_LOD = 4'd2,
        OP_STD = 4'd3,
        OP_JMP = 4'd4,
        OP_CAL = 4'd5,
        OP_A2S = 4'd6,
        OP_S2A = 4'd7,
        OP_LDS = 4'd8,
        OP_STS = 4'd9
    } opcode_t;

    typedef enum logic [1:0] {ASRC_MBR, ASRC_SUM, ASRC_DIFF, ASRC_SREG} a_src_t;
    typedef enum logic [1:0] {PSRC_INC, PSRC_TGT, PSRC_TGT_INC, PSRC_HOLD} pc_src_t;
    typedef enum logic [1:0] {MSRC_FIELD, MSRC_SREG, MSRC_NEXT_PC, MSRC_HOLD} mar_src_t;
    typedef enum logic [1:0] {DSRC_MEM, DSRC_ACC, DSRC_PC, DSRC_HOLD} mbr_src_t;

    typedef struct packed {
        logic     ld_ir;
        logic     ld_tmp;
        logic     ld_a;
        a_src_t   a_src;
        logic     ld_s;
        logic     ld_pc;
        pc_src_t  pc_src;
        logic     ld_mar;
        mar_src_t mar_src;
        logic     ld_mbr;
        mbr_src_t mbr_src;
        logic     rd;
        logic     wr;
    } ctl_t;

    function automatic logic addr_from_sreg(input logic [OPC_W-1:0] op);
        return (op == OP_LDS) || (op == OP_STS);
    endfunction

    function automatic logic staged_operand(input logic [OPC_W-1:0] op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction

endpackage

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] dec_op,
    input  logic [OPC_W-1:0] ir_op,
    output phase_t           phase,
    output ctl_t             ctl
);

    phase_t phase_q, phase_d;
    logic   second_q, second_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_FETCH;
            second_q <= 1'b0;
        end else begin
            phase_q  <= phase_d;
            second_q <= second_d;
        end
    end

    assign phase = phase_q;

    always_comb begin
        ctl      = '0;
        phase_d  = phase_q;
        second_d = 1'b0;
        unique case (phase_q)
            PH_FETCH: begin
                ctl.rd      = 1'b1;
                ctl.ld_mbr  = 1'b1;
                ctl.mbr_src = DSRC_MEM;
                ctl.ld_pc   = 1'b1;
                ctl.pc_src  = PSRC_INC;
                phase_d     = PH_DECODE;
            end
            PH_DECODE: begin
                ctl.ld_ir   = 1'b1;
                ctl.ld_mar  = 1'b1;
                ctl.mar_src = addr_from_sreg(dec_op) ? MSRC_SREG : MSRC_FIELD;
                phase_d     = PH_OPERAND;
            end
            PH_OPERAND: begin
                phase_d = PH_EXEC;
                if (staged_operand(ir_op)) begin
                    if (!second_q) begin
                        ctl.rd      = 1'b1;
                        ctl.ld_mbr  = 1'b1;
                        ctl.mbr_src = DSRC_MEM;
                        second_d    = 1'b1;
                        phase_d     = PH_OPERAND;
                    end else begin
                        ctl.ld_tmp  = 1'b1;
                    end
                end else begin
                    case (ir_op)
                        OP_LOD, OP_LDS: begin
                            ctl.rd      = 1'b1;
                            ctl.ld_mbr  = 1'b1;
                            ctl.mbr_src = DSRC_MEM;
                        end
                        OP_STD, OP_STS: begin
                            ctl.ld_mbr  = 1'b1;
                            ctl.mbr_src = DSRC_ACC;
                        end
                        OP_CAL: begin
                            ctl.ld_mbr  = 1'b1;
                            ctl.mbr_src = DSRC_PC;
                        end
                        default: ;
                    endcase
                end
            end
            PH_EXEC: begin
                ctl.ld_mar  = 1'b1;
                ctl.mar_src = MSRC_NEXT_PC;
                phase_d     = PH_FETCH;
                case (ir_op)
                    OP_ADD: begin ctl.ld_a = 1'b1; ctl.a_src = ASRC_SUM;  end
                    OP_SUB: begin ctl.ld_a = 1'b1; ctl.a_src = ASRC_DIFF; end
                    OP_LOD, OP_LDS: begin ctl.ld_a = 1'b1; ctl.a_src = ASRC_MBR; end
                    OP_S2A: begin ctl.ld_a = 1'b1; ctl.a_src = ASRC_SREG; end
                    OP_A2S: ctl.ld_s = 1'b1;
                    OP_STD, OP_STS: ctl.wr = 1'b1;
                    OP_JMP: begin ctl.ld_pc = 1'b1; ctl.pc_src = PSRC_TGT; end
                    OP_CAL: begin
                        ctl.wr     = 1'b1;
                        ctl.ld_pc  = 1'b1;
                        ctl.pc_src = PSRC_TGT_INC;
                    end
                    default: ;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/acc_cpu_dp.sv
module acc_cpu_dp
    import acc_cpu_pkg::*;
#(
    parameter  int DATA_W = WORD_W,
    localparam int ADDR_W = DATA_W - OPC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_t              ctl,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mar,
    output logic [DATA_W-1:0] mbr,
    output logic [OPC_W-1:0]  mbr_op,
    output logic [OPC_W-1:0]  ir_op,
    output logic [ADDR_W-1:0] pc,
    output logic [DATA_W-1:0] sreg,
    output logic [DATA_W-1:0] tmp
);

    localparam logic [ADDR_W-1:0] ONE_A = {{(ADDR_W-1){1'b0}}, 1'b1};

    logic [DATA_W-1:0] acc, ir;
    logic [DATA_W-1:0] acc_next, mbr_next;
    logic [ADDR_W-1:0] pc_next, mar_next, ir_addr;

    assign ir_addr = ir[ADDR_W-1:0];
    assign ir_op   = ir[DATA_W-1 -: OPC_W];
    assign mbr_op  = mbr[DATA_W-1 -: OPC_W];

    always_comb begin
        pc_next = pc;
        if (ctl.ld_pc) begin
            case (ctl.pc_src)
                PSRC_INC:     pc_next = pc + ONE_A;
                PSRC_TGT:     pc_next = ir_addr;
                PSRC_TGT_INC: pc_next = ir_addr + ONE_A;
                default:      pc_next = pc;
            endcase
        end
    end

    always_comb begin
        case (ctl.a_src)
            ASRC_SUM:  acc_next = acc + tmp;
            ASRC_DIFF: acc_next = acc - tmp;
            ASRC_SREG: acc_next = sreg;
            default:   acc_next = mbr;
        endcase
    end

    always_comb begin
        case (ctl.mbr_src)
            DSRC_MEM: mbr_next = rd_data;
            DSRC_ACC: mbr_next = acc;
            DSRC_PC:  mbr_next = {{OPC_W{1'b0}}, pc};
            default:  mbr_next = mbr;
        endcase
    end

    always_comb begin
        case (ctl.mar_src)
            MSRC_FIELD:   mar_next = mbr[ADDR_W-1:0];
            MSRC_SREG:    mar_next = sreg[ADDR_W-1:0];
            MSRC_NEXT_PC: mar_next = pc_next;
            default:      mar_next = mar;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            tmp  <= '0;
            ir   <= '0;
            pc   <= '0;
            sreg <= '0;
            mar  <= '0;
            mbr  <= '0;
        end else begin
            pc <= pc_next;
            if (ctl.ld_a)   acc  <= acc_next;
            if (ctl.ld_tmp) tmp  <= mbr;
            if (ctl.ld_ir)  ir   <= mbr;
            if (ctl.ld_s)   sreg <= acc;
            if (ctl.ld_mar) mar  <= mar_next;
            if (ctl.ld_mbr) mbr  <= mbr_next;
        end
    end

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter  int DATA_W = WORD_W,
    localparam int ADDR_W = DATA_W - OPC_W
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    ctl_t              ctl;
    phase_t            phase;
    logic [OPC_W-1:0]  mbr_op, ir_op;
    logic [ADDR_W-1:0] pc_q;
    logic [DATA_W-1:0] s_q, tmp_q;

    acc_cpu_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .dec_op (mbr_op),
        .ir_op  (ir_op),
        .phase  (phase),
        .ctl    (ctl)
    );

    acc_cpu_dp #(.DATA_W(DATA_W)) u_dp (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .rd_data (mem_rdata),
        .mar     (mem_addr),
        .mbr     (mem_wdata),
        .mbr_op  (mbr_op),
        .ir_op   (ir_op),
        .pc      (pc_q),
        .sreg    (s_q),
        .tmp     (tmp_q)
    );

    assign mem_re = ctl.rd;
    assign mem_we = ctl.wr;

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
    import acc_cpu_pkg::*;
#(
    parameter  int DATA_W = WORD_W,
    localparam int ADDR_W = DATA_W - OPC_W
) (
    input logic              clk,
    input logic              rst,
    input phase_t            phase,
    input logic [OPC_W-1:0]  ir_op,
    input logic [ADDR_W-1:0] pc,
    input logic [DATA_W-1:0] s,
    input logic [DATA_W-1:0] tmp,
    input logic              mem_re,
    input logic              mem_we
);

    AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FETCH) |=> (phase == PH_DECODE));                          // R1
    AST_DECODE_TO_OPERAND: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DECODE) |=> (phase == PH_OPERAND));                        // R1
    AST_EXEC_TO_FETCH: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXEC) |=> (phase == PH_FETCH));                            // R1
    AST_PC_STEP_ON_FETCH: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FETCH) |=> (pc == $past(pc) + 1'b1));                      // R3
    AST_TMP_ONLY_IN_OPERAND: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_OPERAND) |=> $stable(tmp));                                // R4
    AST_SREG_ONLY_BY_A2S: assert property (@(posedge clk) disable iff (rst)
        !(phase == PH_EXEC && ir_op == OP_A2S) |=> $stable(s));                 // R9
    AST_WRITE_IN_EXEC: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (phase == PH_EXEC));                                         // R11
    AST_NO_READ_WRITE_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));                                                   // R11

endmodule

bind acc_cpu acc_cpu_chk #(.DATA_W(DATA_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .phase  (phase),
    .ir_op  (ir_op),
    .pc     (pc_q),
    .s      (s_q),
    .tmp    (tmp_q),
    .mem_re (mem_re),
    .mem_we (mem_we)
);

// File: tb/tb_acc_cpu.sv
`timescale 1ns/1ps
module tb_acc_cpu;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] mem_addr;
    logic        mem_re, mem_we;
    logic [15:0] mem_wdata, mem_rdata;

    logic [15:0] mem [0:255];
    int n_chk  = 0;
    int n_fail = 0;
    int wr_cnt = 0;

    always #4 clk = ~clk;

    acc_cpu dut (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_re    (mem_re),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

    assign mem_rdata = mem[mem_addr[7:0]];

    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr[7:0]] = mem_wdata;
            wr_cnt = wr_cnt + 1;
        end
    end

    function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] a);
        return {op, a};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        rst = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    endtask

    task automatic start();
        rst = 1'b1;
        wr_cnt = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        clear_mem();
        mem[0] = ins(4'h3, 12'h090);
        mem[1] = ins(4'h7, 12'h000);
        mem[2] = ins(4'h3, 12'h091);
        mem[3] = ins(4'h4, 12'h003);
        mem[8'h90] = 16'hAAAA;
        mem[8'h91] = 16'hBBBB;
        start();
        chk("R2 fetch addr", {4'h0, mem_addr}, 16'h0000);
        chk("R2 read strobe", {15'h0, mem_re}, 16'h0001);
        chk("R2 write strobe", {15'h0, mem_we}, 16'h0000);
        run(40);
        chk("R2 acc cleared", mem[8'h90], 16'h0000);
        chk("R2 sreg cleared", mem[8'h91], 16'h0000);
    endtask

    task automatic t_timing();
        int first_wr = -1;
        clear_mem();
        mem[0] = ins(4'h0, 12'h080);
        mem[1] = ins(4'h3, 12'h090);
        mem[2] = ins(4'h4, 12'h002);
        start();
        for (int k = 0; k < 20; k++) begin
            if (k == 5) begin
                chk("R3 fetch of second word addr", {4'h0, mem_addr}, 16'h0001);
                chk("R3 fetch of second word strobe", {15'h0, mem_re}, 16'h0001);
            end
            if (mem_we && first_wr < 0) begin
                first_wr = k;
                chk("R11 no read with write", {15'h0, mem_re}, 16'h0000);
                chk("R11 write address", {4'h0, mem_addr}, 16'h0090);
            end
            @(negedge clk);
        end
        chk("R1 store cycle after ADD", 16'(first_wr), 16'd8);
    endtask

    task automatic t_arith();
        clear_mem();
        mem[0] = ins(4'h2, 12'h080);
        mem[1] = ins(4'h3, 12'h092);
        mem[2] = ins(4'h0, 12'h081);
        mem[3] = ins(4'h1, 12'h082);
        mem[4] = ins(4'h3, 12'h090);
        mem[5] = ins(4'h4, 12'h005);
        mem[8'h80] = 16'd23;
        mem[8'h81] = 16'd46;
        mem[8'h82] = 16'd10;
        start();
        run(60);
        chk("R5 LOD then STD", mem[8'h92], 16'd23);
        chk("R4 add then sub", mem[8'h90], 16'd59);
        chk("R5 STD leaves source", mem[8'h80], 16'd23);
    endtask

    task automatic t_wrap();
        clear_mem();
        mem[0] = ins(4'h2, 12'h080);
        mem[1] = ins(4'h0, 12'h081);
        mem[2] = ins(4'h3, 12'h090);
        mem[3] = ins(4'h1, 12'h082);
        mem[4] = ins(4'h3, 12'h091);
        mem[5] = ins(4'h4, 12'h005);
        mem[8'h80] = 16'hFFFF;
        mem[8'h81] = 16'h0002;
        mem[8'h82] = 16'h0003;
        start();
        run(60);
        chk("R4 add wraps", mem[8'h90], 16'h0001);
        chk("R4 sub borrows", mem[8'h91], 16'hFFFE);
    endtask

    task automatic t_sreg();
        clear_mem();
        mem[0] = ins(4'h2, 12'h080);
        mem[1] = ins(4'h6, 12'h000);
        mem[2] = ins(4'h2, 12'h081);
        mem[3] = ins(4'h9, 12'h000);
        mem[4] = ins(4'h2, 12'h082);
        mem[5] = ins(4'h8, 12'h000);
        mem[6] = ins(4'h3, 12'h090);
        mem[7] = ins(4'h7, 12'h000);
        mem[8] = ins(4'h3, 12'h091);
        mem[9] = ins(4'h4, 12'h009);
        mem[8'h80] = 16'h0085;
        mem[8'h81] = 16'h1234;
        mem[8'h82] = 16'h0000;
        start();
        run(80);
        chk("R9 STS via sreg", mem[8'h85], 16'h1234);
        chk("R9 LDS via sreg", mem[8'h90], 16'h1234);
        chk("R8 A2S then S2A, sreg kept", mem[8'h91], 16'h0085);
    endtask

    task automatic t_call();
        clear_mem();
        mem[0] = ins(4'h5, 12'h040);
        mem[1] = ins(4'h3, 12'h091);
        mem[2] = ins(4'h4, 12'h002);
        mem[8'h41] = ins(4'h2, 12'h080);
        mem[8'h42] = ins(4'h3, 12'h090);
        mem[8'h43] = ins(4'h4, 12'h001);
        mem[8'h80] = 16'd7;
        start();
        run(60);
        chk("R7 return address saved", mem[8'h40], 16'h0001);
        chk("R7 resumes at target+1", mem[8'h90], 16'd7);
        chk("R6 JMP lands, A kept", mem[8'h91], 16'd7);
    endtask

    task automatic t_nop();
        clear_mem();
        mem[0] = ins(4'h2, 12'h080);
        mem[1] = ins(4'hA, 12'h023);
        mem[2] = ins(4'hF, 12'h080);
        mem[3] = ins(4'h3, 12'h090);
        mem[4] = ins(4'h4, 12'h004);
        mem[8'h80] = 16'd5;
        mem[8'h23] = 16'h5555;
        start();
        run(60);
        chk("R10 A kept over no-ops", mem[8'h90], 16'd5);
        chk("R10 no write at field", mem[8'h23], 16'h5555);
        chk("R10 operand cell kept", mem[8'h80], 16'd5);
        chk("R10 single write total", 16'(wr_cnt), 16'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_timing();
        t_arith();
        t_wrap();
        t_sreg();
        t_call();
        t_nop();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule